// File: doc/BRIEF.md
# SPI Flash User-Mode Byte Bridge

This block lets software talk to SPI flash chips one raw byte at a time. Each chip select has its own control register and its own access window. Software first writes the chip's control register to put it in user mode, which asserts that chip's select line. Each write to the chip's window then sends the written bytes out on the serial data line. Each read from the window clocks in as many bytes as the access is wide. The chip select stays low across any number of window accesses. It is released only when software sets the stop bit in the control register. As a result, an opcode, an address, dummy bytes and a data phase can be built from separate bus accesses.

The window works as a byte FIFO. The access size decides how many bytes move. The low address bits are used only to check that the access is aligned, so bytes never move to a different position because of them. A global configuration register holds one write-enable bit per chip. A window write to a chip whose bit is clear is refused. A refused access, whatever the cause, is answered at once with an error and never reaches the serial lines. While a transfer is in progress the window bus is stalled. The master must hold its request until `win_ready` pulses.

Top module: `spi_user_bridge`

## Requirements
- R1: Register address 0 is the global configuration register. Register address 1+k is the control register of chip k: bits [1:0] are the mode and bit 2 is the stop bit. `spi_cs_n[k]` is low exactly when chip k has mode 3 and stop 0. It changes in the cycle after the register write. After reset every chip select is high.
- R2: Writing mode 3 with stop 1 holds the select high. A following write of mode 3 with stop 0 asserts it again. Once asserted, the select stays low through any number of window accesses until the stop bit is written back to 1.
- R3: Bit 16+k of the configuration register enables window writes to chip k. A window write to chip k while that bit is 0 produces no serial clock. Its only effect is one `win_ready` pulse with `win_err` high. Reads do not need the bit.
- R4: `win_size` codes 0, 1 and 2 mean 1, 2 and 4 bytes (N). A write sends 8·N bits. Byte `win_wdata[7:0]` goes first, then the higher byte lanes in ascending order. Each byte is sent most significant bit first. `spi_mosi` stays stable while `spi_sclk` is high.
- R5: A read drives `spi_mosi` low while it captures 8·N bits. The first byte received lands in `win_rdata[7:0]`, later bytes land in ascending lanes, and unused upper lanes read as zero.
- R6: `spi_sclk` idles low. Each half period lasts SCK_HALF clocks. `spi_miso` is sampled on the rising edge, and `spi_mosi` moves after the falling edge.
- R7: `win_ready` is a single-cycle pulse. It arrives 16·SCK_HALF·N clock edges after the edge that accepted the request. The request must stay asserted until that pulse.
- R8: The access is refused with an error if it is misaligned (a 2-byte access with address bit 0 set, or a 4-byte access with address bits [1:0] nonzero) or if `win_size` is code 3.
- R9: The access is refused with an error if the selected chip is not in active user mode (mode other than 3, or stop 1), or if the chip index is NUM_CS or above.
- R10: The address bits below the access size do not change the serial bytes. For example, a 1-byte write at offset 3 sends the same bits as one at offset 0.
- R11: A register write and a window request in the same cycle: the request is judged against the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register index (0 config, 1+k control of chip k) |
| reg_wdata | input | 32 | Register write data |
| win_req | input | 1 | Window access request, held until win_ready |
| win_write | input | 1 | 1 = write access, 0 = read access |
| win_sel | input | SEL_W | Chip window index |
| win_addr | input | 2 | Low address bits of the access inside the window |
| win_size | input | 2 | Access size code: 0 byte, 1 half word, 2 word |
| win_wdata | input | 32 | Write data, byte lanes in ascending order |
| win_ready | output | 1 | One-cycle completion pulse |
| win_err | output | 1 | Set together with win_ready on a refused access |
| win_rdata | output | 32 | Read data, valid with win_ready |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A register update and a window request can arrive in the same cycle. The access check reads register state that the same clock edge is changing. The bench creates this collision in two ways. In the first, a configuration write that clears a chip's write enable is driven in the same cycle as a write request to that chip; the request must still be accepted and shifted. In the second, a write that sets the enable coincides with a request made while the bit is clear; that request must be refused. A cycle-accurate reference model applies the register write only after judging the request. It then compares the chip selects, serial lines, handshake and read data on every clock.

// File: rtl/spi_user_bridge_pkg.sv
`timescale 1ns/1ps
package spi_user_bridge_pkg;

    // access size codes carried on win_size
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // mode field value that hands the chip to software
    localparam logic [1:0] MODE_USER = 2'd3;

    // bit position of chip 0's write-enable in the configuration register
    localparam int WE_LSB = 16;

    typedef struct packed {
        logic [1:0] mode;
        logic       stop;
    } chip_ctl_t;

    function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
        case (code)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    // reverse byte lanes: lowest lane ends up in the most significant byte
    function automatic logic [31:0] lane_swap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/sub_regfile.sv
`timescale 1ns/1ps
module sub_regfile
    import spi_user_bridge_pkg::*;
#(
    parameter int NUM_CS = 3,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [NUM_CS-1:0] wr_en_o,
    output logic [NUM_CS-1:0] active_o,
    output logic [NUM_CS-1:0] cs_n_o
);

    typedef struct packed {
        logic [NUM_CS-1:0]            wr_en;
        chip_ctl_t [NUM_CS-1:0]       ctl;
    } rf_t;

    rf_t rf_d, rf_q;

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^{reg_wdata[31:WE_LSB+NUM_CS], reg_wdata[WE_LSB-1:3]};

    always_comb begin
        rf_d = rf_q;
        if (reg_we) begin
            if (reg_addr == '0) begin
                rf_d.wr_en = reg_wdata[WE_LSB +: NUM_CS];
            end
            for (int k = 0; k < NUM_CS; k++) begin
                if (reg_addr == REG_AW'(k + 1)) begin
                    rf_d.ctl[k].mode = reg_wdata[1:0];
                    rf_d.ctl[k].stop = reg_wdata[2];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q.wr_en <= '0;
            for (int k = 0; k < NUM_CS; k++) begin
                rf_q.ctl[k].mode <= 2'd0;
                rf_q.ctl[k].stop <= 1'b1;
            end
        end else begin
            rf_q <= rf_d;
        end
    end

    assign wr_en_o = rf_q.wr_en;

    for (genvar k = 0; k < NUM_CS; k++) begin : g_chip
        assign active_o[k] = (rf_q.ctl[k].mode == MODE_USER) && !rf_q.ctl[k].stop;
        assign cs_n_o[k]   = ~active_o[k];

        // stop bit written high releases the select on the next cycle
        p_stop_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == REG_AW'(k + 1) && reg_wdata[2]) |=> cs_n_o[k]);

        // user mode with stop clear selects the chip on the next cycle
        p_user_selects_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == REG_AW'(k + 1) && reg_wdata[1:0] == MODE_USER && !reg_wdata[2])
            |=> !cs_n_o[k]);

        // without a control write the select level holds
        p_cs_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_we && reg_addr == REG_AW'(k + 1)) |=> $stable(cs_n_o[k]));
    end

endmodule

// File: rtl/sub_access_check.sv
`timescale 1ns/1ps
module sub_access_check
    import spi_user_bridge_pkg::*;
#(
    parameter int NUM_CS = 3,
    parameter int SEL_W  = 2
) (
    input  logic              write_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [1:0]        addr_lo_i,
    input  logic [1:0]        size_i,
    input  logic [NUM_CS-1:0] active_i,
    input  logic [NUM_CS-1:0] wr_en_i,
    output logic              bad_o
);

    typedef struct packed {
        logic sel_ok;
        logic act;
        logic wen;
        logic misaligned;
        logic size_bad;
    } chk_t;

    chk_t c;

    always_comb begin
        c = '0;
        for (int k = 0; k < NUM_CS; k++) begin
            if (sel_i == SEL_W'(k)) begin
                c.sel_ok = 1'b1;
                c.act    = active_i[k];
                c.wen    = wr_en_i[k];
            end
        end
        c.size_bad   = (size_to_bytes(size_i) == 3'd0);
        c.misaligned = ((size_i == SZ_HALF) && addr_lo_i[0]) ||
                       ((size_i == SZ_WORD) && (addr_lo_i != 2'b00));
        bad_o = c.size_bad || c.misaligned || !c.sel_ok || !c.act ||
                (write_i && !c.wen);
    end

endmodule

// File: rtl/sub_shift_engine.sv
`timescale 1ns/1ps
module sub_shift_engine
    import spi_user_bridge_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        bad_i,
    input  logic        write_i,
    input  logic [1:0]  size_i,
    input  logic [31:0] wdata_i,
    input  logic        miso_i,
    output logic        sclk_o,
    output logic        mosi_o,
    output logic        ready_o,
    output logic        err_o,
    output logic [31:0] rdata_o
);

    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);

    typedef struct packed {
        logic             busy;
        logic             sclk;
        logic [DIV_W-1:0] div;
        logic [5:0]       bits;
        logic [2:0]       nbytes;
        logic [31:0]      tx;
        logic [31:0]      rx;
        logic             ready;
        logic             err;
        logic [31:0]      rdata;
    } eng_t;

    eng_t e_d, e_q;

    function automatic logic [31:0] gather(input logic [31:0] rx, input logic [2:0] nb);
        case (nb)
            3'd1:    return {24'd0, rx[7:0]};
            3'd2:    return {16'd0, rx[7:0], rx[15:8]};
            default: return lane_swap(rx);
        endcase
    endfunction

    always_comb begin
        e_d       = e_q;
        e_d.ready = 1'b0;
        e_d.err   = 1'b0;
        if (e_q.busy) begin
            if (e_q.div == DIV_LAST) begin
                e_d.div = '0;
                if (!e_q.sclk) begin
                    e_d.sclk = 1'b1;
                    e_d.rx   = {e_q.rx[30:0], miso_i};
                end else begin
                    e_d.sclk = 1'b0;
                    e_d.tx   = {e_q.tx[30:0], 1'b0};
                    e_d.bits = e_q.bits - 6'd1;
                    if (e_q.bits == 6'd1) begin
                        e_d.busy  = 1'b0;
                        e_d.ready = 1'b1;
                        e_d.rdata = gather(e_q.rx, e_q.nbytes);
                    end
                end
            end else begin
                e_d.div = e_q.div + DIV_W'(1);
            end
        end else if (start_i && !e_q.ready) begin
            if (bad_i) begin
                e_d.ready = 1'b1;
                e_d.err   = 1'b1;
            end else begin
                e_d.busy   = 1'b1;
                e_d.sclk   = 1'b0;
                e_d.div    = '0;
                e_d.nbytes = size_to_bytes(size_i);
                e_d.bits   = {size_to_bytes(size_i), 3'b000};
                e_d.tx     = write_i ? lane_swap(wdata_i) : 32'd0;
                e_d.rx     = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign sclk_o  = e_q.sclk;
    assign mosi_o  = e_q.busy & e_q.tx[31];
    assign ready_o = e_q.ready;
    assign err_o   = e_q.err;
    assign rdata_o = e_q.rdata;

    p_sclk_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !e_q.busy |-> !sclk_o);

    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);

    p_err_with_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ready_o);

    // a refused request (R3, R8, R9) never starts the serial clock
    p_refused_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!e_q.busy && !e_q.ready && start_i && bad_i) |=> (!e_q.busy && err_o && !sclk_o));

    p_mosi_held_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.busy && sclk_o && e_q.div != DIV_LAST) |=> $stable(mosi_o));

endmodule

// File: rtl/spi_user_bridge.sv
`timescale 1ns/1ps
module spi_user_bridge
    import spi_user_bridge_pkg::*;
#(
    parameter int NUM_CS   = 3,
    parameter int REG_AW   = 4,
    parameter int SCK_HALF = 2,
    localparam int SEL_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              win_req,
    input  logic              win_write,
    input  logic [SEL_W-1:0]  win_sel,
    input  logic [1:0]        win_addr,
    input  logic [1:0]        win_size,
    input  logic [31:0]       win_wdata,
    output logic              win_ready,
    output logic              win_err,
    output logic [31:0]       win_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic [NUM_CS-1:0] spi_cs_n,
    input  logic              spi_miso
);

    logic [NUM_CS-1:0] wr_en;
    logic [NUM_CS-1:0] active;
    logic              bad;

    sub_regfile #(.NUM_CS(NUM_CS), .REG_AW(REG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .wr_en_o   (wr_en),
        .active_o  (active),
        .cs_n_o    (spi_cs_n)
    );

    sub_access_check #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_check (
        .write_i   (win_write),
        .sel_i     (win_sel),
        .addr_lo_i (win_addr),
        .size_i    (win_size),
        .active_i  (active),
        .wr_en_i   (wr_en),
        .bad_o     (bad)
    );

    sub_shift_engine #(.SCK_HALF(SCK_HALF)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (win_req),
        .bad_i   (bad),
        .write_i (win_write),
        .size_i  (win_size),
        .wdata_i (win_wdata),
        .miso_i  (spi_miso),
        .sclk_o  (spi_sclk),
        .mosi_o  (spi_mosi),
        .ready_o (win_ready),
        .err_o   (win_err),
        .rdata_o (win_rdata)
    );

    // the serial clock only runs while the master holds its request (R7)
    p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> win_req);

endmodule

// File: tb/spi_user_bridge_tb.sv
`timescale 1ns/1ps
module spi_user_bridge_tb;

    localparam int NCS  = 3;
    localparam int HALF = 2;
    localparam int RAW  = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           reg_we = 1'b0;
    logic [RAW-1:0] reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic           win_req = 1'b0, win_write = 1'b0;
    logic [1:0]     win_sel = '0, win_addr = '0, win_size = '0;
    logic [31:0]    win_wdata = '0;
    logic           win_ready, win_err, spi_sclk, spi_mosi;
    logic [31:0]    win_rdata;
    logic [NCS-1:0] spi_cs_n;
    logic           spi_miso = 1'b0;

    spi_user_bridge #(.NUM_CS(NCS), .REG_AW(RAW), .SCK_HALF(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .win_req(win_req), .win_write(win_write),
        .win_sel(win_sel), .win_addr(win_addr), .win_size(win_size),
        .win_wdata(win_wdata), .win_ready(win_ready), .win_err(win_err),
        .win_rdata(win_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
    );

    int tests = 0, fails = 0;
    bit chk_on = 0;

    // reference model state
    bit          m_busy, m_wr, m_ready, m_err, m_rd_ok;
    int          m_t, m_total, m_nb;
    bit          txq[$];
    logic [31:0] m_rdata, resp;
    bit [NCS-1:0] m_we;
    logic [1:0]  m_mode[NCS];
    bit          m_stop[NCS];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin : model
        bit prev, bad;
        int nb;
        if (!rst_n) begin
            m_busy = 0; m_ready = 0; m_err = 0; m_rd_ok = 0; m_we = '0;
            for (int k = 0; k < NCS; k++) begin m_mode[k] = 2'd0; m_stop[k] = 1; end
        end else begin
            prev = m_ready; m_ready = 0; m_err = 0; m_rd_ok = 0;
            if (m_busy) begin
                m_t++;
                if (m_t == m_total) begin
                    m_busy = 0; m_ready = 1;
                    if (!m_wr) begin
                        m_rd_ok = 1;
                        m_rdata = (m_nb == 1) ? (resp & 32'hFF) :
                                  (m_nb == 2) ? (resp & 32'hFFFF) : resp;
                    end
                end
            end else if (win_req && !prev) begin
                nb = (win_size == 2'd0) ? 1 : (win_size == 2'd1) ? 2 : (win_size == 2'd2) ? 4 : 0;
                bad = (nb == 0) || (nb == 2 && win_addr[0]) || (nb == 4 && win_addr != 2'b00) ||
                      (int'(win_sel) >= NCS);
                if (!bad)
                    bad = !(m_mode[win_sel] == 2'd3 && !m_stop[win_sel]) || (win_write && !m_we[win_sel]);
                if (bad) begin
                    m_ready = 1; m_err = 1;
                end else begin
                    m_busy = 1; m_t = 0; m_nb = nb; m_total = 16 * HALF * nb; m_wr = win_write;
                    txq.delete();
                    for (int i = 0; i < 8 * nb; i++)
                        txq.push_back(win_write ? win_wdata[8 * (i / 8) + 7 - (i % 8)] : 1'b0);
                end
            end
            // register update lands after the request was judged (R11)
            if (reg_we) begin
                if (reg_addr == 0) m_we = reg_wdata[16 +: NCS];
                else if (int'(reg_addr) <= NCS) begin
                    m_mode[int'(reg_addr) - 1] = reg_wdata[1:0];
                    m_stop[int'(reg_addr) - 1] = reg_wdata[2];
                end
            end
        end
    end

    // flash response: next bit presented for the coming rising edge
    always @(negedge clk) begin : flash_drv
        int idx;
        idx = m_t / (2 * HALF);
        if (m_busy && !m_wr) spi_miso <= resp[8 * (idx / 8) + 7 - (idx % 8)];
        else spi_miso <= 1'b0;
    end

    always @(negedge clk) begin : compare
        logic [NCS-1:0] ecs;
        logic esclk, emosi;
        if (chk_on) begin
            for (int k = 0; k < NCS; k++) ecs[k] = !(m_mode[k] == 2'd3 && !m_stop[k]);
            esclk = m_busy ? logic'((m_t / HALF) % 2) : 1'b0;
            emosi = (m_busy && m_wr) ? txq[m_t / (2 * HALF)] : 1'b0;
            check(spi_cs_n === ecs, "R1 cs_n per cycle", 32'(spi_cs_n), 32'(ecs));
            check(spi_sclk === esclk, "R6 sclk per cycle", 32'(spi_sclk), 32'(esclk));
            check(spi_mosi === emosi, "R4 mosi per cycle", 32'(spi_mosi), 32'(emosi));
            check(win_ready === m_ready, "R7 ready timing", 32'(win_ready), 32'(m_ready));
            check(win_err === m_err, "R8 err flag", 32'(win_err), 32'(m_err));
            if (m_rd_ok) check(win_rdata === m_rdata, "R5 read data model", win_rdata, m_rdata);
        end
    end

    task automatic reg_write(input logic [RAW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic access(input bit wr, input logic [1:0] sel, input logic [1:0] addr,
                          input logic [1:0] size, input logic [31:0] data, input bit exp_err,
                          input string tag, input bit coll = 0,
                          input logic [RAW-1:0] ra = '0, input logic [31:0] rd = '0);
        int n;
        @(negedge clk);
        win_req = 1; win_write = wr; win_sel = sel; win_addr = addr; win_size = size; win_wdata = data;
        if (coll) begin reg_we = 1; reg_addr = ra; reg_wdata = rd; end
        n = 0;
        do begin
            @(negedge clk);
            reg_we = 0;
            n++;
        end while (!win_ready && n < 5000);
        check(win_ready && (win_err == exp_err), tag, 32'(win_err), 32'(exp_err));
        win_req = 0;
    endtask

    task automatic read_chk(input logic [1:0] sel, input logic [1:0] addr, input logic [1:0] size,
                            input logic [31:0] exp, input string tag);
        access(0, sel, addr, size, 32'h0, 0, tag);
        check(win_rdata === exp, tag, win_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        resp = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_on = 1;
        check(spi_cs_n === 3'b111, "R1 reset selects high", 32'(spi_cs_n), 32'h7);
        check(spi_sclk === 1'b0, "R6 reset sclk low", 32'(spi_sclk), 0);
        check(win_ready === 1'b0, "R7 reset ready low", 32'(win_ready), 0);

        access(1, 2'd0, 2'd0, 2'd0, 32'h9F, 1, "R9 chip not in user mode");

        reg_write(4'd1, 32'h7);
        check(spi_cs_n === 3'b111, "R2 stop bit holds select high", 32'(spi_cs_n), 32'h7);
        reg_write(4'd1, 32'h3);
        check(spi_cs_n === 3'b110, "R2 fresh select assertion", 32'(spi_cs_n), 32'h6);

        access(1, 2'd0, 2'd0, 2'd0, 32'h06, 1, "R3 write without enable refused");
        resp = 32'h0000_0081;
        read_chk(2'd0, 2'd0, 2'd0, 32'h81, "R3 read needs no enable");

        reg_write(4'd0, 32'h1 << 16);
        access(1, 2'd0, 2'd0, 2'd2, 32'h0012_3403, 0, "R4 word write opcode+address");
        access(1, 2'd0, 2'd3, 2'd0, 32'h0000_00A5, 0, "R10 byte at offset 3");
        access(1, 2'd0, 2'd2, 2'd1, 32'h0000_BEEF, 0, "R10 half at offset 2");
        check(spi_cs_n === 3'b110, "R2 select held across accesses", 32'(spi_cs_n), 32'h6);

        resp = 32'hC35A_817E;
        read_chk(2'd0, 2'd0, 2'd0, 32'h0000_007E, "R5 byte read");
        read_chk(2'd0, 2'd2, 2'd1, 32'h0000_817E, "R5 half read");
        read_chk(2'd0, 2'd0, 2'd2, 32'hC35A_817E, "R5 word read");

        access(1, 2'd0, 2'd1, 2'd1, 32'h1, 1, "R8 misaligned half");
        access(0, 2'd0, 2'd2, 2'd2, 32'h0, 1, "R8 misaligned word");
        access(1, 2'd0, 2'd1, 2'd2, 32'h0, 1, "R8 misaligned word odd");
        access(1, 2'd0, 2'd0, 2'd3, 32'h0, 1, "R8 size code 3");
        access(1, 2'd3, 2'd0, 2'd0, 32'h0, 1, "R9 chip index out of range");
        access(0, 2'd2, 2'd0, 2'd0, 32'h0, 1, "R9 idle chip window");

        access(1, 2'd0, 2'd0, 2'd0, 32'h11, 0, "R11 enable cleared same cycle still accepted",
               1, 4'd0, 32'h0);
        access(1, 2'd0, 2'd0, 2'd0, 32'h22, 1, "R3 enable now clear");
        access(1, 2'd0, 2'd0, 2'd0, 32'h33, 1, "R11 enable set same cycle still refused",
               1, 4'd0, 32'h1 << 16);
        access(1, 2'd0, 2'd0, 2'd1, 32'h5A3C, 0, "R11 enable effective afterwards");

        reg_write(4'd1, 32'h7);
        check(spi_cs_n === 3'b111, "R2 end sequence releases select", 32'(spi_cs_n), 32'h7);
        reg_write(4'd1, 32'h0);
        check(spi_cs_n === 3'b111, "R1 default mode keeps select high", 32'(spi_cs_n), 32'h7);
        access(0, 2'd0, 2'd0, 2'd0, 32'h0, 1, "R9 access after end sequence");

        reg_write(4'd0, 32'h2 << 16);
        reg_write(4'd2, 32'h7);
        reg_write(4'd2, 32'h3);
        check(spi_cs_n === 3'b101, "R1 second chip selected", 32'(spi_cs_n), 32'h5);
        access(1, 2'd1, 2'd0, 2'd1, 32'h0000_F00D, 0, "R4 half write chip 1");
        resp = 32'h1234_5678;
        read_chk(2'd1, 2'd0, 2'd2, 32'h1234_5678, "R5 word read chip 1");
        reg_write(4'd0, 32'h1 << 16);
        access(1, 2'd1, 2'd0, 2'd0, 32'h77, 1, "R3 enable of other chip only");

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule